// File: doc/BRIEF.md
# Sector Hamming Check-and-Repair Unit

This unit takes the 24-bit Hamming parity word kept in a flash page's spare area and the matching word computed by hardware while the data streamed in, and decides for every 512-byte sector whether the data is clean, holds one flipped bit that can be repaired, or is damaged beyond repair. The XOR of the two words forms a syndrome. The number of ones in the syndrome sets the class. A syndrome of weight twelve gives the position of the bad bit directly.

A caller presents the parity words for all sectors at once and pulses `start`. The unit then walks one sector or a full four-sector page. When a sector is repairable, the unit reads the affected byte through a byte-wide buffer port, XORs in a one-hot mask, and writes the byte back before it moves to the next sector. A page in the erased state (stored word all ones, computed word all zeros) counts as clean. Each sector ends with a report pulse. The walk ends with a done pulse, either after the last sector or at the first sector that cannot be repaired.

Top module: `ecc_sector_fix`

## Requirements
- R1: After reset, `busy`, `sec_valid`, `done`, `buf_rd_en` and `buf_we` are all low.
- R2: A sector whose stored and computed words are equal is reported with status 0 (clean), with `err_byte` and `err_bit` zero, and the buffer is not touched.
- R3: Within each 24-bit word, bits [11:0] hold the even parities P1e..P2048e and bits [23:12] hold the odd parities P1o..P2048o, lowest order first. Sector s uses bits [24s+23:24s] of the code buses. A syndrome of weight 12 is reported with status 1 (corrected). `err_bit` is syndrome bits [14:12] (P1o..P4o). `err_byte` is s*512 plus syndrome bits [23:15] (P8o..P2048o).
- R4: A correction issues exactly one buffer read at `err_byte`. In the next cycle it writes the returned byte XOR (1 << `err_bit`) to the same address. The write happens before that sector's report and before the next sector is evaluated.
- R5: A syndrome of weight 1 or 11 is reported with status 2 (uncorrectable), and the buffer is not touched.
- R6: Any other nonzero syndrome weight is also reported with status 2, unless R7 applies.
- R7: A stored word of all ones together with a computed word of all zeros is reported as clean. A stored word of all ones with any other computed word is not exempt.
- R8: With `page_mode` high, sectors 0 to 3 are reported in ascending order through `sec_num`. With it low, only sector 0 is evaluated, and the words of the higher sectors have no effect.
- R9: The walk stops at the first uncorrectable sector. No later sector is reported or repaired.
- R10: `done` pulses exactly once per walk, in the same cycle as the final `sec_valid` pulse.
- R11: While `busy` is high, `start`, `page_mode` and the code buses are ignored. The words are captured only when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted while idle) |
| page_mode | input | 1 | 1: four sectors, 0: sector 0 only |
| stored_code | input | 96 | Parity words read from the spare area, sector 0 in the low bits |
| calc_code | input | 96 | Parity words computed by hardware, same layout |
| busy | output | 1 | Walk in progress |
| sec_valid | output | 1 | One-cycle sector report strobe |
| sec_num | output | 2 | Sector being reported |
| sec_status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |
| err_byte | output | 11 | Page byte offset of the repaired bit |
| err_bit | output | 3 | Bit index within that byte |
| done | output | 1 | One-cycle end-of-walk strobe |
| buf_rd_en | output | 1 | Buffer read request; data is returned on the next cycle |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 11 | Buffer byte address |
| buf_wdata | output | 8 | Repaired byte |
| buf_rdata | input | 8 | Byte returned one cycle after a read |

## Verification
The bench uses the default parameters: 512-byte sectors (nine byte-index bits, 24-bit words) and four sectors per page. This gives a 2048-byte address space, so the sector base and the extreme offsets 0x000 and 0x7FF can be checked, and the weights 1, 11 and 12 line up with the 24-bit syndrome. Syndromes are built in the bench from a chosen bit address, and the buffer model holds the whole page, so every repair can be confirmed by reading the byte back.

// File: rtl/ecc_sector_fix.sv
module ecc_sector_fix #(
  parameter int SECT_LOG2 = 9,
  parameter int MAX_SECT  = 4
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic                                           start,
  input  logic                                           page_mode,
  input  logic [2*(SECT_LOG2+3)*MAX_SECT-1:0]            stored_code,
  input  logic [2*(SECT_LOG2+3)*MAX_SECT-1:0]            calc_code,
  output logic                                           busy,
  output logic                                           sec_valid,
  output logic [$clog2(MAX_SECT)-1:0]                    sec_num,
  output logic [1:0]                                     sec_status,
  output logic [SECT_LOG2+$clog2(MAX_SECT)-1:0]          err_byte,
  output logic [2:0]                                     err_bit,
  output logic                                           done,
  output logic                                           buf_rd_en,
  output logic                                           buf_we,
  output logic [SECT_LOG2+$clog2(MAX_SECT)-1:0]          buf_addr,
  output logic [7:0]                                     buf_wdata,
  input  logic [7:0]                                     buf_rdata
);
  localparam int LOC_W  = SECT_LOG2 + 3;
  localparam int CODE_W = 2 * LOC_W;
  localparam int SEC_W  = $clog2(MAX_SECT);
  localparam int ADDR_W = SECT_LOG2 + SEC_W;
  localparam int BUS_W  = CODE_W * MAX_SECT;
  localparam int WT_W   = $clog2(CODE_W + 1);
  localparam logic [1:0] ST_CLEAN = 2'd0;
  localparam logic [1:0] ST_FIXED = 2'd1;
  localparam logic [1:0] ST_BAD   = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_RD, S_WR} state_t;

  state_t              state;
  logic [BUS_W-1:0]    st_q, cc_q;
  logic                page_q;
  logic [SEC_W-1:0]    sec_q;
  logic [CODE_W-1:0]   st_cur, cc_cur, syn;
  logic [WT_W-1:0]     wt;
  logic                erased, is_last;
  logic [1:0]          cls;
  logic                valid_q, done_q;
  logic [1:0]          status_q;
  logic [SEC_W-1:0]    num_q;
  logic [ADDR_W-1:0]   byte_q;
  logic [2:0]          bit_q;

  assign st_cur  = st_q[int'(sec_q)*CODE_W +: CODE_W];
  assign cc_cur  = cc_q[int'(sec_q)*CODE_W +: CODE_W];
  assign syn     = st_cur ^ cc_cur;
  assign erased  = (st_cur == {CODE_W{1'b1}}) && (cc_cur == '0);
  assign is_last = !page_q || (sec_q == SEC_W'(MAX_SECT - 1));

  always_comb begin
    wt = '0;
    for (int i = 0; i < CODE_W; i++) wt = wt + WT_W'(syn[i]);
  end

  always_comb begin
    if (syn == '0 || erased)        cls = ST_CLEAN;
    else if (wt == WT_W'(LOC_W))    cls = ST_FIXED;
    else                            cls = ST_BAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      st_q     <= '0;
      cc_q     <= '0;
      page_q   <= 1'b0;
      sec_q    <= '0;
      valid_q  <= 1'b0;
      done_q   <= 1'b0;
      status_q <= ST_CLEAN;
      num_q    <= '0;
      byte_q   <= '0;
      bit_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          st_q   <= stored_code;
          cc_q   <= calc_code;
          page_q <= page_mode;
          sec_q  <= '0;
          state  <= S_EVAL;
        end
        S_EVAL: begin
          num_q    <= sec_q;
          status_q <= cls;
          if (cls == ST_FIXED) begin
            byte_q <= {sec_q, syn[CODE_W-1:LOC_W+3]};
            bit_q  <= syn[LOC_W+2:LOC_W];
            state  <= S_RD;
          end else begin
            byte_q  <= '0;
            bit_q   <= '0;
            valid_q <= 1'b1;
            if (cls == ST_BAD || is_last) begin
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              sec_q <= sec_q + SEC_W'(1);
            end
          end
        end
        S_RD: state <= S_WR;
        S_WR: begin
          valid_q <= 1'b1;
          if (is_last) begin
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            sec_q <= sec_q + SEC_W'(1);
            state <= S_EVAL;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy       = (state != S_IDLE);
  assign sec_valid  = valid_q;
  assign done       = done_q;
  assign sec_status = status_q;
  assign sec_num    = num_q;
  assign err_byte   = byte_q;
  assign err_bit    = bit_q;
  assign buf_rd_en  = (state == S_RD);
  assign buf_we     = (state == S_WR);
  assign buf_addr   = byte_q;
  assign buf_wdata  = buf_rdata ^ (8'd1 << bit_q);
endmodule

// File: rtl/ecc_sector_fix_chk.sv
module ecc_sector_fix_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              sec_valid,
  input logic              done,
  input logic [1:0]        sec_status,
  input logic              buf_rd_en,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!buf_rd_en && !buf_we)); // R1
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(buf_rd_en)); // R4
  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (buf_addr == $past(buf_addr))); // R4
  AST_FIX_REPORT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_status == 2'd1) |-> $past(buf_we)); // R4
  AST_NO_WRITE_UNFIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_status != 2'd1) |-> !$past(buf_we)); // R5
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sec_valid |-> (sec_status != 2'd3)); // R6
  AST_BAD_ENDS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_status == 2'd2) |-> done); // R9
  AST_DONE_WITH_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sec_valid); // R10
endmodule

bind ecc_sector_fix ecc_sector_fix_chk #(.ADDR_W(SECT_LOG2 + $clog2(MAX_SECT))) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sec_valid(sec_valid), .done(done),
  .sec_status(sec_status), .buf_rd_en(buf_rd_en), .buf_we(buf_we), .buf_addr(buf_addr));

// File: tb/ecc_sector_fix_bench.sv
`timescale 1ns/1ps
module ecc_sector_fix_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        page = 1'b0;
  logic [95:0] stored = '0;
  logic [95:0] calc = '0;
  logic        busy, sec_valid, done, buf_rd_en, buf_we;
  logic [1:0]  sec_num, sec_status;
  logic [10:0] err_byte, buf_addr;
  logic [2:0]  err_bit;
  logic [7:0]  buf_wdata, buf_rdata;

  always #2.5 clk = ~clk;

  ecc_sector_fix u_ecc_sector_fix (
    .clk(clk), .rst_n(rst_n), .start(start), .page_mode(page),
    .stored_code(stored), .calc_code(calc), .busy(busy), .sec_valid(sec_valid),
    .sec_num(sec_num), .sec_status(sec_status), .err_byte(err_byte), .err_bit(err_bit),
    .done(done), .buf_rd_en(buf_rd_en), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .buf_rdata(buf_rdata));

  logic [7:0] mem [0:2047];
  int rd_cnt = 0, wr_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) mem[i] <= 8'(i * 7 + 3);
      buf_rdata <= 8'h00;
    end else begin
      if (buf_rd_en) begin buf_rdata <= mem[buf_addr]; rd_cnt <= rd_cnt + 1; end
      if (buf_we)    begin mem[buf_addr] <= buf_wdata; wr_cnt <= wr_cnt + 1; end
    end
  end

  function automatic logic [7:0] gold(input int a);
    return 8'(a * 7 + 3);
  endfunction

  function automatic logic [23:0] flip_syn(input logic [11:0] loc);
    return {loc, ~loc};
  endfunction

  int total = 0, bad = 0;
  int n_rep, n_done, done_lone, rd_d, wr_d;
  logic [1:0]  r_st [0:3];
  logic [10:0] r_by [0:3];
  logic [2:0]  r_bi [0:3];
  logic [1:0]  r_sn [0:3];

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic pm, input logic [95:0] st, input logic [95:0] cc,
                     input logic glitch);
    int rd0, wr0;
    n_rep = 0; n_done = 0; done_lone = 0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    @(negedge clk);
    stored = st; calc = cc; page = pm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 80; k++) begin
      if (glitch && k == 1) begin start = 1'b1; page = 1'b0; stored = ~st; end
      if (glitch && k == 2) start = 1'b0;
      if (sec_valid) begin
        if (n_rep < 4) begin
          r_st[n_rep] = sec_status; r_by[n_rep] = err_byte;
          r_bi[n_rep] = err_bit;    r_sn[n_rep] = sec_num;
        end
        n_rep++;
      end
      if (done) begin
        n_done++;
        if (!sec_valid) done_lone++;
      end
      @(negedge clk);
    end
    start = 1'b0;
    rd_d = rd_cnt - rd0; wr_d = wr_cnt - wr0;
    chk(n_done == 1, "R10", "done pulses", n_done, 1);
    chk(done_lone == 0, "R10", "done without report", done_lone, 0);
  endtask

  task automatic exp_rep(input int i, input logic [1:0] s, input logic [10:0] by,
                         input logic [2:0] bi, input logic [1:0] sn, input string req);
    chk(r_st[i] == s,  req, "status", r_st[i], s);
    chk(r_by[i] == by, req, "err_byte", r_by[i], by);
    chk(r_bi[i] == bi, req, "err_bit", r_bi[i], bi);
    chk(r_sn[i] == sn, "R8", "sec_num", r_sn[i], sn);
  endtask

  localparam logic [23:0] C0 = 24'h5A3C96, C1 = 24'h13E7A0, C2 = 24'hC40F5B, C3 = 24'h8D2261;

  task automatic t_reset();
    chk(!busy && !sec_valid && !done, "R1", "status outputs", {busy, sec_valid, done}, 0);
    chk(!buf_rd_en && !buf_we, "R1", "buffer strobes", {buf_rd_en, buf_we}, 0);
  endtask

  task automatic t_clean();
    run(1'b0, {72'h0, C0}, {72'h0, C0}, 1'b0);
    chk(n_rep == 1, "R2", "reports", n_rep, 1);
    exp_rep(0, 2'd0, 11'h0, 3'd0, 2'd0, "R2");
    chk(rd_d == 0 && wr_d == 0, "R2", "buffer accesses", rd_d + wr_d, 0);
  endtask

  task automatic t_fix_single();
    run(1'b0, {72'h0, C0 ^ flip_syn({9'h1A5, 3'd6})}, {72'h0, C0}, 1'b0);
    chk(n_rep == 1, "R3", "reports", n_rep, 1);
    exp_rep(0, 2'd1, 11'h1A5, 3'd6, 2'd0, "R3");
    chk(rd_d == 1 && wr_d == 1, "R4", "read+write count", rd_d * 16 + wr_d, 17);
    chk(mem[11'h1A5] == (gold(11'h1A5) ^ 8'h40), "R4", "repaired byte", mem[11'h1A5], gold(11'h1A5) ^ 8'h40);
  endtask

  task automatic t_weights();
    run(1'b0, {72'h0, C0 ^ 24'h000001}, {72'h0, C0}, 1'b0);
    exp_rep(0, 2'd2, 11'h0, 3'd0, 2'd0, "R5");
    chk(wr_d == 0, "R5", "writes on weight 1", wr_d, 0);
    run(1'b0, {72'h0, C1 ^ 24'h0007FF}, {72'h0, C1}, 1'b0);
    exp_rep(0, 2'd2, 11'h0, 3'd0, 2'd0, "R5");
    chk(wr_d == 0, "R5", "writes on weight 11", wr_d, 0);
    run(1'b0, {72'h0, C2 ^ 24'h000003}, {72'h0, C2}, 1'b0);
    exp_rep(0, 2'd2, 11'h0, 3'd0, 2'd0, "R6");
    run(1'b0, {72'h0, C3 ^ 24'hFFF0FF}, {72'h0, C3}, 1'b0);
    exp_rep(0, 2'd2, 11'h0, 3'd0, 2'd0, "R6");
  endtask

  task automatic t_erased();
    run(1'b0, {72'h0, 24'hFFFFFF}, {72'h0, 24'h000000}, 1'b0);
    exp_rep(0, 2'd0, 11'h0, 3'd0, 2'd0, "R7");
    chk(wr_d == 0, "R7", "writes on erased page", wr_d, 0);
    run(1'b0, {72'h0, 24'hFFFFFF}, {72'h0, 24'h000001}, 1'b0);
    exp_rep(0, 2'd2, 11'h0, 3'd0, 2'd0, "R7");
  endtask

  task automatic t_page_mix();
    run(1'b1, {C3 ^ flip_syn({9'h1FF, 3'd7}), 24'hFFFFFF, C1 ^ flip_syn(12'h000), C0},
              {C3, 24'h000000, C1, C0}, 1'b0);
    chk(n_rep == 4, "R8", "reports", n_rep, 4);
    exp_rep(0, 2'd0, 11'h000, 3'd0, 2'd0, "R2");
    exp_rep(1, 2'd1, 11'h200, 3'd0, 2'd1, "R3");
    exp_rep(2, 2'd0, 11'h000, 3'd0, 2'd2, "R7");
    exp_rep(3, 2'd1, 11'h7FF, 3'd7, 2'd3, "R3");
    chk(wr_d == 2, "R4", "writes", wr_d, 2);
    chk(mem[11'h200] == (gold(11'h200) ^ 8'h01), "R4", "byte 0x200", mem[11'h200], gold(11'h200) ^ 8'h01);
    chk(mem[11'h7FF] == (gold(11'h7FF) ^ 8'h80), "R4", "byte 0x7FF", mem[11'h7FF], gold(11'h7FF) ^ 8'h80);
  endtask

  task automatic t_stop();
    run(1'b1, {C3, C2 ^ flip_syn({9'h033, 3'd1}), C1 ^ 24'h0007FF, C0 ^ flip_syn({9'h010, 3'd2})},
              {C3, C2, C1, C0}, 1'b0);
    chk(n_rep == 2, "R9", "reports", n_rep, 2);
    exp_rep(0, 2'd1, 11'h010, 3'd2, 2'd0, "R3");
    exp_rep(1, 2'd2, 11'h000, 3'd0, 2'd1, "R9");
    chk(wr_d == 1, "R9", "writes", wr_d, 1);
    chk(mem[11'h433] == gold(11'h433), "R9", "later sector untouched", mem[11'h433], gold(11'h433));
    chk(mem[11'h010] == (gold(11'h010) ^ 8'h04), "R4", "byte 0x010", mem[11'h010], gold(11'h010) ^ 8'h04);
  endtask

  task automatic t_single_ignores_upper();
    run(1'b0, {C3 ^ 24'h1, C2 ^ 24'h1, C1 ^ 24'h1, C0}, {C3, C2, C1, C0}, 1'b0);
    chk(n_rep == 1, "R8", "reports in single mode", n_rep, 1);
    exp_rep(0, 2'd0, 11'h0, 3'd0, 2'd0, "R8");
  endtask

  task automatic t_busy_start();
    run(1'b1, {C3, C2, C1, C0}, {C3, C2, C1, C0}, 1'b1);
    chk(n_rep == 4, "R11", "reports despite restart", n_rep, 4);
    for (int i = 0; i < 4; i++)
      chk(r_st[i] == 2'd0 && r_sn[i] == 2'(i), "R11", "status/sector", {r_st[i], r_sn[i]}, i);
  endtask

  initial begin
    logic timed_out;
    timed_out = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_clean();
        t_fix_single();
        t_weights();
        t_erased();
        t_page_mix();
        t_stop();
        t_single_ignores_upper();
        t_busy_start();
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "watchdog", "run ended", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule